// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that lets a bus host read and write a small register file. It watches SCL and SDA, recognises START and STOP, and compares the first byte after a START with its own 7-bit address. The upper six bits of that address are a parameter. The lowest bit comes from a strap input that is captured while reset is held.

In a write transfer, the byte after the address loads an internal register pointer. Every following byte is written to the register that the pointer selects. In a read transfer, bytes are taken from the register file at the current pointer and shifted out. The top bit of the pointer byte is an increment flag. When it is set, the pointer advances after each byte, so the host can read or write a block of registers. When it is clear, the pointer stays on one register.

The register file sits outside the block and is reached through a plain port: an address that is always valid, a combinational read-data return, and a one-cycle write strobe. SDA is split into a sampled input and a pull-low output that the chip pad turns into an open-drain driver.

Top module: `i2c_regslave`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address decoding from any state. A rising SDA while SCL is high (STOP) returns the block to idle with SDA released. After a STOP, bytes clocked on the bus are neither acknowledged nor acted on until the next START.
- R2: The first byte after START is taken as address bits [7:1] and a direction bit [0], where 1 means read and 0 means write. When bits [7:1] equal {DEV_HI, strap}, the block pulls SDA low for the ninth clock. Otherwise it never pulls SDA and ignores the bus until the next START.
- R3: The strap input is sampled on every clock while rst_n is low. After reset its captured value is held, and later changes on the strap pin have no effect.
- R4: In a write, the byte after the address is the pointer byte: bit 7 is the increment flag and bits 6:0 are the register index. Each later byte is acknowledged and written to the register at the pointer by a reg_we pulse that lasts exactly one clock.
- R5: With the increment flag set, the pointer advances by one after every data byte written or read. With it clear, every byte uses the same register.
- R6: In a read, each byte comes from the register at the current pointer and is placed on SDA most significant bit first. Each bit is set up while SCL is low.
- R7: In a read, SDA is released during the host's acknowledge slot. A host ACK (SDA low) starts the next byte. A host NACK ends the transfer: SDA stays released on every later clock until a START.
- R8: A repeated START without a STOP keeps the pointer loaded by the preceding write. The pointer is also kept across a STOP, so a later read resumes where the last transfer left off.
- R9: SDA is only ever pulled low or released. After reset, sda_pull and reg_we are 0.
- R10: SCL and SDA pass through a two-stage synchronizer and an edge detector. The acknowledge pull therefore appears on the third rising clock edge after scl_i falls at the end of the eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the strap is captured while it is low |
| strap_a0 | input | 1 | Strap that supplies the lowest address bit |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | PTR_W | Register index, equal to the current pointer |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
Every bus result is due a fixed number of system clocks after the SCL edge that causes it. Two synchronizer stages and one edge register make the change visible in the third clock after an SCL fall. This holds for the acknowledge pull, for each read bit and for the release of SDA. A register write lands in the clock after that. The bench drives the bus from tasks with ten clocks per quarter bit, so it samples SDA in the middle of each SCL high phase and checks register contents only after a whole byte, well past those latencies. The acknowledge latency itself is measured by polling sda_pull on every falling system-clock edge after the eighth SCL fall and comparing the count with three.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int PTR_W = 7,
  parameter logic [5:0] DEV_HI = 6'b100101,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_a0,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_PTR, P_DATA} ph_t;

  logic [SYNC_N-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q, a0_q;
  st_t st;
  ph_t ph;
  logic [3:0] bitcnt;
  logic [7:0] rxsh;
  logic [6:0] txsh;
  logic [PTR_W-1:0] ptr;
  logic incr, rd, mack;

  wire scl_s = scl_sy[SYNC_N-1];
  wire sda_s = sda_sy[SYNC_N-1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c = scl_s & scl_q & ~sda_q & sda_s;

  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) a0_q <= strap_a0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_N-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_N-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= P_ADDR;
      bitcnt <= '0;
      rxsh <= '0;
      txsh <= '0;
      ptr <= '0;
      incr <= 1'b0;
      rd <= 1'b0;
      mack <= 1'b0;
      sda_pull <= 1'b0;
      reg_we <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we && incr) ptr <= ptr + PTR_ONE;
      if (start_c) begin
        st <= S_RX;
        ph <= P_ADDR;
        bitcnt <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              rxsh <= {rxsh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              case (ph)
                P_ADDR: begin
                  if (rxsh[7:1] == {DEV_HI, a0_q}) begin
                    sda_pull <= 1'b1;
                    rd <= rxsh[0];
                    ph <= P_PTR;
                    st <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                P_PTR: begin
                  ptr <= rxsh[PTR_W-1:0];
                  incr <= rxsh[7];
                  sda_pull <= 1'b1;
                  ph <= P_DATA;
                  st <= S_ACK;
                end
                default: begin
                  reg_wdata <= rxsh;
                  reg_we <= 1'b1;
                  sda_pull <= 1'b1;
                  st <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (rd) begin
                txsh <= reg_rdata[6:0];
                sda_pull <= ~reg_rdata[7];
                if (incr) ptr <= ptr + PTR_ONE;
                st <= S_TX;
              end else begin
                sda_pull <= 1'b0;
                st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_pull <= 1'b0;
                bitcnt <= '0;
                st <= S_MACK;
              end else begin
                sda_pull <= ~txsh[6];
                txsh <= {txsh[5:0], 1'b0};
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                txsh <= reg_rdata[6:0];
                sda_pull <= ~reg_rdata[7];
                if (incr) ptr <= ptr + PTR_ONE;
                st <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull,
  input logic reg_we,
  input logic a0_q
);

  assert_we_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_we_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sda_pull);

  assert_we_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_i);

  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_i);

  assert_strap_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(a0_q));

endmodule

bind i2c_regslave i2c_regslave_chk chk (
  .clk(clk),
  .rst_n(rst_n),
  .scl_i(scl_i),
  .sda_pull(sda_pull),
  .reg_we(reg_we),
  .a0_q(a0_q)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_a0 = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] rf [128];
  wire sda_line = sda_m & ~sda_pull;

  int n_chk = 0;
  int n_fail = 0;
  bit ack;
  int lat;
  logic [7:0] d;

  always #4 clk = ~clk;

  i2c_regslave uut (
    .clk(clk), .rst_n(rst_n), .strap_a0(strap_a0),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = rf[reg_addr];
  always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

  function automatic logic [7:0] ival(int i);
    return 8'(i * 7 + 8'h31);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output int alat);
    alat = -1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0;
      for (int k = 1; k <= Q; k++) begin
        tick(1);
        if (i == 0 && sda_pull && alat < 0) alat = k;
      end
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q / 2);
    acked = ~sda_line;
    tick(Q / 2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      v[i] = sda_line;
      tick(Q / 2);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = nack; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic t_reset;
    check(sda_pull == 1'b0, "R9 reset sda_pull", sda_pull, 0);
    check(reg_we == 1'b0, "R9 reset reg_we", reg_we, 0);
  endtask

  task automatic t_addr_match;
    bus_start;
    send_byte(8'h96, ack, lat);
    check(ack, "R2 R3 address with strap bit acked", ack, 1);
    bus_stop;
  endtask

  task automatic t_addr_miss;
    bus_start;
    send_byte(8'h94, ack, lat);
    check(!ack, "R2 R3 address with stale strap bit not acked", ack, 0);
    send_byte(8'h05, ack, lat);
    check(!ack, "R2 byte after miss not acked", ack, 0);
    send_byte(8'h77, ack, lat);
    bus_stop;
    check(rf[5] == ival(5), "R2 no write after miss", rf[5], ival(5));
  endtask

  task automatic t_stop_idle;
    bus_start;
    send_byte(8'h96, ack, lat);
    bus_stop;
    scl_m = 1'b0; tick(Q);
    send_byte(8'h96, ack, lat);
    check(!ack, "R1 no ack after STOP without START", ack, 0);
    bus_stop;
  endtask

  task automatic t_write_fixed;
    bus_start;
    send_byte(8'h96, ack, lat);
    check(lat == 3, "R10 ack latency", lat, 3);
    send_byte(8'h05, ack, lat);
    check(ack, "R4 pointer byte acked", ack, 1);
    send_byte(8'h11, ack, lat);
    send_byte(8'h22, ack, lat);
    check(ack, "R4 data byte acked", ack, 1);
    bus_stop;
    check(rf[5] == 8'h22, "R5 fixed pointer last write", rf[5], 8'h22);
    check(rf[6] == ival(6), "R5 fixed pointer neighbour untouched", rf[6], ival(6));
  endtask

  task automatic t_write_burst;
    bus_start;
    send_byte(8'h96, ack, lat);
    send_byte(8'h90, ack, lat);
    send_byte(8'hA1, ack, lat);
    send_byte(8'hB2, ack, lat);
    send_byte(8'hC3, ack, lat);
    bus_stop;
    check(rf[16] == 8'hA1, "R4 R5 burst byte 0", rf[16], 8'hA1);
    check(rf[17] == 8'hB2, "R5 burst byte 1", rf[17], 8'hB2);
    check(rf[18] == 8'hC3, "R5 burst byte 2", rf[18], 8'hC3);
    check(rf[19] == ival(19), "R5 burst end", rf[19], ival(19));
  endtask

  task automatic t_read_rstart;
    bus_start;
    send_byte(8'h96, ack, lat);
    send_byte(8'h90, ack, lat);
    bus_start;
    send_byte(8'h97, ack, lat);
    check(ack, "R8 read address after repeated START acked", ack, 1);
    recv_byte(1'b0, d);
    check(d == 8'hA1, "R6 R8 read byte 0", d, 8'hA1);
    recv_byte(1'b0, d);
    check(d == 8'hB2, "R5 R7 read byte 1 after host ACK", d, 8'hB2);
    recv_byte(1'b1, d);
    check(d == 8'hC3, "R5 read byte 2", d, 8'hC3);
    tick(Q);
    check(sda_pull == 1'b0, "R7 released after NACK", sda_pull, 0);
    bus_stop;
  endtask

  task automatic t_read_resume;
    bus_start;
    send_byte(8'h97, ack, lat);
    recv_byte(1'b1, d);
    bus_stop;
    check(d == ival(19), "R8 pointer kept across STOP", d, ival(19));
  endtask

  task automatic t_read_fixed;
    int low;
    bus_start;
    send_byte(8'h96, ack, lat);
    send_byte(8'h05, ack, lat);
    bus_start;
    send_byte(8'h97, ack, lat);
    recv_byte(1'b0, d);
    check(d == 8'h22, "R6 fixed read byte 0", d, 8'h22);
    recv_byte(1'b1, d);
    check(d == 8'h22, "R5 fixed read byte 1", d, 8'h22);
    low = 0;
    for (int p = 0; p < 9; p++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      if (!sda_line) low++;
      tick(Q / 2);
      scl_m = 1'b0; tick(Q);
    end
    check(low == 0, "R7 silent after NACK", low, 0);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) rf[i] = ival(i);
    tick(10);
    rst_n = 1'b1;
    tick(2);
    strap_a0 = 1'b0;
    tick(5);
    t_reset;
    t_addr_match;
    t_addr_miss;
    t_stop_idle;
    t_write_fixed;
    t_write_burst;
    t_read_rstart;
    t_read_resume;
    t_read_fixed;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule